// File: doc/BRIEF.md
# Lane Deskew Calibration Burst Generator

This block produces the calibration burst that a receiver uses to line up the skew between the data lanes of a four-lane high-speed serial link. Each cycle it delivers one 16-bit parallel word per lane to an external 16:1 serializer, so one cycle carries 16 unit intervals (UI) per lane. A burst is one all-ones word followed by a run of alternating-bit words, and every lane carries the same word in the same cycle.

There are two kinds of burst. An initial burst is sent once when the link comes up. A periodic burst is sent again later. Each kind has its own length register, written in UI. The block raises the length to the kind's minimum, lowers it to the kind's maximum, and rounds it up to whole words. A burst is started either by a software strobe or by a hardware pulse, and each of these carries its own kind select. `busy_o` covers the whole burst, and `done_o` pulses once when the burst ends.

Top module: `deskew_burst_gen`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0, and whenever `busy_o` is 0 every lane word is 0x0000.
- R2: The cycle after an accepted trigger, `busy_o` is 1 and every lane carries 0xFFFF for exactly one cycle.
- R3: Every following burst word is 0xAAAA on all four lanes at once. Bit 0 is 0, and the serializer sends the LSB first, so the first bit on the wire is 0.
- R4: The number of 0xAAAA words is ceil(L/16). L is the length register of the selected kind, raised to that kind's minimum and lowered to its maximum. Initial bursts use 32768 to 250000 UI and periodic bursts use 1024 to 25000 UI. Both registers reset to 0.
- R5: A write with `cfg_wr_i`=1 stores `cfg_wdata_i` in the initial length register when `cfg_sel_i`=0 and in the periodic length register when `cfg_sel_i`=1. A kind value of 0 selects an initial burst and 1 selects a periodic burst.
- R6: `sw_start_i` starts a burst of kind `sw_kind_i`, and `hw_start_i` starts a burst of kind `hw_kind_i`. If both are high in the same cycle, the software kind is used.
- R7: A trigger that arrives while `busy_o` is 1 is ignored. The running burst keeps its length, and no second burst follows it.
- R8: The length is captured when a burst starts. A register write during a burst affects only later bursts.
- R9: `busy_o` stays 1 from the 0xFFFF word through the last 0xAAAA word. In the next cycle `busy_o` is 0 and `done_o` is 1 for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Length register write strobe |
| cfg_sel_i | input | 1 | Register select: 0 initial, 1 periodic |
| cfg_wdata_i | input | 18 | Length in UI |
| sw_start_i | input | 1 | Software start strobe |
| sw_kind_i | input | 1 | Kind for software start: 0 initial, 1 periodic |
| hw_start_i | input | 1 | Hardware start pulse |
| hw_kind_i | input | 1 | Kind for hardware start |
| lane_data_o | output | 64 | Four 16-bit lane words, lane 0 in bits 15:0 |
| busy_o | output | 1 | A burst is in progress |
| done_o | output | 1 | One-cycle pulse after the last burst word |

## Verification
The length path is driven with values exactly on each bound, one below and one above a bound, and a single UI past a word edge (1024, 1025, 1040, 1041, 0, 60000, 262143). These separate a missing clamp, a missing round-up and a round-off by one word, and some of them also show whether the two registers or the two kinds have been swapped. Each burst is run from both trigger sources, and the bench checks the 0xFFFF word, every 0xAAAA word, the word count and the done pulse. Directed cases then cover:
- both triggers high in the same cycle;
- triggers that arrive in the middle of a burst;
- register writes that arrive in the middle of a burst.

Together these show whether the trigger priority, the ignore-while-busy rule and the length capture at start are in place.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_ALT  = 2'd2
  } burst_state_e;

  localparam logic KIND_INIT     = 1'b0;
  localparam logic KIND_PERIODIC = 1'b1;
endpackage

// File: rtl/dsk_len_regs.sv
module dsk_len_regs #(
  parameter int LEN_W       = 18,
  parameter int WORD_W      = 16,
  parameter int MIN_INIT_UI = 32768,
  parameter int MAX_INIT_UI = 250000,
  parameter int MIN_PER_UI  = 1024,
  parameter int MAX_PER_UI  = 25000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_wr_i,
  input  logic             cfg_sel_i,
  input  logic [LEN_W-1:0] cfg_wdata_i,
  input  logic             kind_i,
  output logic [LEN_W-1:0] words_o
);
  import deskew_pkg::*;

  localparam logic [LEN_W-1:0] INIT_LO = LEN_W'(MIN_INIT_UI);
  localparam logic [LEN_W-1:0] INIT_HI = LEN_W'(MAX_INIT_UI);
  localparam logic [LEN_W-1:0] PER_LO  = LEN_W'(MIN_PER_UI);
  localparam logic [LEN_W-1:0] PER_HI  = LEN_W'(MAX_PER_UI);
  localparam logic [LEN_W-1:0] INIT_W_LO = LEN_W'((MIN_INIT_UI + WORD_W - 1) / WORD_W);
  localparam logic [LEN_W-1:0] INIT_W_HI = LEN_W'((MAX_INIT_UI + WORD_W - 1) / WORD_W);
  localparam logic [LEN_W-1:0] PER_W_LO  = LEN_W'((MIN_PER_UI + WORD_W - 1) / WORD_W);
  localparam logic [LEN_W-1:0] PER_W_HI  = LEN_W'((MAX_PER_UI + WORD_W - 1) / WORD_W);

  logic [LEN_W-1:0] init_len_q, per_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_len_q <= '0;
      per_len_q  <= '0;
    end else if (cfg_wr_i) begin
      if (cfg_sel_i) per_len_q  <= cfg_wdata_i;
      else           init_len_q <= cfg_wdata_i;
    end
  end

  // clamp in UI, then round up to whole words
  function automatic logic [LEN_W-1:0] to_words(logic [LEN_W-1:0] v,
                                                logic [LEN_W-1:0] lo,
                                                logic [LEN_W-1:0] hi);
    logic [LEN_W-1:0] c;
    logic [LEN_W:0]   r;
    c = (v < lo) ? lo : ((v > hi) ? hi : v);
    r = ({1'b0, c} + (LEN_W+1)'(WORD_W - 1)) / (LEN_W+1)'(WORD_W);
    return r[LEN_W-1:0];
  endfunction

  always_comb begin
    if (kind_i == KIND_PERIODIC) words_o = to_words(per_len_q, PER_LO, PER_HI);
    else                         words_o = to_words(init_len_q, INIT_LO, INIT_HI);
  end

  AST_INIT_WORDS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == KIND_INIT) |-> (words_o >= INIT_W_LO && words_o <= INIT_W_HI)); // R4
  AST_PER_WORDS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == KIND_PERIODIC) |-> (words_o >= PER_W_LO && words_o <= PER_W_HI)); // R4
endmodule

// File: rtl/dsk_burst_seq.sv
module dsk_burst_seq #(
  parameter int CNT_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] words_i,
  output logic             pre_o,
  output logic             alt_o,
  output logic             busy_o,
  output logic             done_o
);
  import deskew_pkg::*;

  burst_state_e     state_q;
  logic [CNT_W-1:0] words_q, cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      words_q <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          words_q <= words_i;
          state_q <= ST_PRE;
        end
        ST_PRE: begin
          cnt_q   <= CNT_W'(1);
          state_q <= ST_ALT;
        end
        ST_ALT: begin
          if (cnt_q == words_q) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pre_o  = (state_q == ST_PRE);
  assign alt_o  = (state_q == ST_ALT);
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  AST_PRE_SINGLE_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PRE) |=> (state_q == ST_ALT)); // R2
  AST_ALT_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ALT) |-> (cnt_q != '0 && cnt_q <= words_q)); // R4
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i) |=> $stable(words_q)); // R7
  AST_LEN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ALT) |=> $stable(words_q)); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R9
endmodule

// File: rtl/dsk_lane_fanout.sv
module dsk_lane_fanout #(
  parameter int LANES  = 4,
  parameter int WORD_W = 16
) (
  input  logic                    pre_i,
  input  logic                    alt_i,
  output logic [LANES*WORD_W-1:0] lanes_o
);
  localparam logic [WORD_W-1:0] PRE_WORD = '1;
  localparam logic [WORD_W-1:0] ALT_WORD = {(WORD_W/2){2'b10}}; // LSB 0 goes first

  logic [WORD_W-1:0] word;

  always_comb begin
    if (pre_i)      word = PRE_WORD;
    else if (alt_i) word = ALT_WORD;
    else            word = '0;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lanes_o[l*WORD_W +: WORD_W] = word;
  end
endmodule

// File: rtl/deskew_burst_gen.sv
module deskew_burst_gen #(
  parameter int LANES       = 4,
  parameter int WORD_W      = 16,
  parameter int LEN_W       = 18,
  parameter int MIN_INIT_UI = 32768,
  parameter int MAX_INIT_UI = 250000,
  parameter int MIN_PER_UI  = 1024,
  parameter int MAX_PER_UI  = 25000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_wr_i,
  input  logic                    cfg_sel_i,
  input  logic [LEN_W-1:0]        cfg_wdata_i,
  input  logic                    sw_start_i,
  input  logic                    sw_kind_i,
  input  logic                    hw_start_i,
  input  logic                    hw_kind_i,
  output logic [LANES*WORD_W-1:0] lane_data_o,
  output logic                    busy_o,
  output logic                    done_o
);
  logic             start, kind, pre, alt;
  logic [LEN_W-1:0] words;

  assign start = sw_start_i | hw_start_i;
  assign kind  = sw_start_i ? sw_kind_i : hw_kind_i; // software wins

  dsk_len_regs #(
    .LEN_W(LEN_W), .WORD_W(WORD_W),
    .MIN_INIT_UI(MIN_INIT_UI), .MAX_INIT_UI(MAX_INIT_UI),
    .MIN_PER_UI(MIN_PER_UI), .MAX_PER_UI(MAX_PER_UI)
  ) u_len (
    .clk_i, .rst_ni, .cfg_wr_i, .cfg_sel_i, .cfg_wdata_i,
    .kind_i(kind), .words_o(words)
  );

  dsk_burst_seq #(.CNT_W(LEN_W)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .words_i(words),
    .pre_o(pre), .alt_o(alt), .busy_o, .done_o
  );

  dsk_lane_fanout #(.LANES(LANES), .WORD_W(WORD_W)) u_fan (
    .pre_i(pre), .alt_i(alt), .lanes_o(lane_data_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (lane_data_o == '0)); // R1
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R9
endmodule

// File: tb/deskew_burst_gen_tb.sv
module deskew_burst_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [17:0] cfg_wdata = '0;
  logic        sw_start = 1'b0, sw_kind = 1'b0, hw_start = 1'b0, hw_kind = 1'b0;
  logic [63:0] lane_data;
  logic        busy, done;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  localparam logic [63:0] ALL_FF = {4{16'hFFFF}};
  localparam logic [63:0] ALL_AA = {4{16'hAAAA}};

  // {kind, use_hw, length_ui, expected_alt_words}
  localparam logic [35:0] VEC [10] = '{
    {1'b1, 1'b0, 18'd1024,   16'd64},
    {1'b1, 1'b1, 18'd1025,   16'd65},
    {1'b1, 1'b0, 18'd1040,   16'd65},
    {1'b1, 1'b1, 18'd1041,   16'd66},
    {1'b1, 1'b0, 18'd25000,  16'd1563},
    {1'b1, 1'b1, 18'd60000,  16'd1563},
    {1'b1, 1'b0, 18'd0,      16'd64},
    {1'b0, 1'b1, 18'd32769,  16'd2049},
    {1'b0, 1'b0, 18'd250000, 16'd15625},
    {1'b0, 1'b1, 18'd262143, 16'd15625}
  };

  always #4 clk = ~clk; // 125 MHz

  deskew_burst_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .sw_start_i(sw_start), .sw_kind_i(sw_kind),
    .hw_start_i(hw_start), .hw_kind_i(hw_kind),
    .lane_data_o(lane_data), .busy_o(busy), .done_o(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 200000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d cycles exp<=200000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_len(input logic sel, input logic [17:0] val);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // mode 1: triggers mid-burst; mode 2: periodic register write mid-burst
  task automatic run_burst(input logic do_sw, input logic do_hw, input logic sk, input logic hk,
                           input int exp_words, input int mode, input string tag);
    int alt_n;
    logic alt_ok;
    @(negedge clk);
    sw_start = do_sw; sw_kind = sk; hw_start = do_hw; hw_kind = hk;
    @(negedge clk);
    sw_start = 1'b0; hw_start = 1'b0;
    chk(busy && lane_data == ALL_FF, {tag, " R2 preamble word"}, lane_data, ALL_FF);
    alt_n = 0; alt_ok = 1'b1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (i == 10 && mode == 1) begin
        sw_start = 1'b1; sw_kind = 1'b0; hw_start = 1'b1; hw_kind = 1'b0;
      end else if (i == 11 && mode == 1) begin
        sw_start = 1'b0; hw_start = 1'b0;
      end
      if (i == 10 && mode == 2) begin
        cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_wdata = 18'd2048;
      end else if (i == 11 && mode == 2) begin
        cfg_wr = 1'b0;
      end
      if (!busy) break;
      if (lane_data != ALL_AA) alt_ok = 1'b0;
      alt_n++;
    end
    chk(alt_ok, {tag, " R3 alternating words on all lanes"}, {63'd0, alt_ok}, 64'd1);
    chk(alt_n == exp_words, {tag, " R4 alternating word count"}, 64'(alt_n), 64'(exp_words));
    chk(done && lane_data == '0, {tag, " R9 done pulse, R1 idle lanes"}, {63'd0, done}, 64'd1);
    @(negedge clk);
    chk(!done && !busy, {tag, " R9 done lasts one cycle"}, {62'd0, done, busy}, 64'd0);
    if (mode == 1) begin
      repeat (3) @(negedge clk);
      chk(!busy, {tag, " R7 no extra burst after ignored triggers"}, {63'd0, busy}, 64'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && lane_data == '0, "R1 reset state", {lane_data}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && lane_data == '0, "R1 idle after reset", lane_data, 64'd0);

    // reset value 0 clamps to initial minimum, hardware trigger
    run_burst(1'b0, 1'b1, 1'b0, 1'b0, 2048, 0, "R4 reset length R6 hw");

    for (int v = 0; v < 10; v++) begin
      wr_len(VEC[v][35], VEC[v][33:16]);                    // R5 register select
      run_burst(!VEC[v][34], VEC[v][34], VEC[v][35], VEC[v][35],
                int'(VEC[v][15:0]), 0, "R4 vector");
    end

    // R5: initial register still holds 262143, periodic 0
    run_burst(1'b1, 1'b0, 1'b1, 1'b1, 64, 0, "R5 periodic reg kept");
    // R6: both triggers, software kind periodic wins over hardware initial
    run_burst(1'b1, 1'b1, 1'b1, 1'b0, 64, 0, "R6 sw priority periodic");
    wr_len(1'b0, 18'd32768);
    run_burst(1'b1, 1'b1, 1'b0, 1'b1, 2048, 0, "R6 sw priority initial");
    // R7: triggers while busy ignored
    wr_len(1'b1, 18'd1024);
    run_burst(1'b0, 1'b1, 1'b1, 1'b1, 64, 1, "R7 busy triggers");
    // R8: write mid-burst affects only the next burst
    run_burst(1'b1, 1'b0, 1'b1, 1'b1, 64, 2, "R8 current burst");
    run_burst(1'b1, 1'b0, 1'b1, 1'b1, 128, 0, "R8 next burst");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule